// File: doc/BRIEF.md
# Double to Legacy Five-Byte Float Converter

This block turns a 64-bit IEEE-754 double into a 40-bit floating-point word in an older five-byte format. That format has no infinity and no NaN. Its first byte is the exponent, biased by 129. The next bit is the sign. The remaining 31 bits hold the fraction, and its leading one is implied rather than stored.

The block does four things. It moves the exponent to the new bias, places the sign after the exponent byte, and rounds the 52-bit fraction to 31 bits by round-to-nearest-even. It also catches values the target cannot hold. Such values either raise an error flag or collapse to zero. One word can be accepted on every clock, and each result appears exactly one clock after its input was taken.

Top module: `f64_to_legacy_float`

## Requirements
- R1: For an input exponent field e whose rebiased value lands in 1..255, `out_data[39:32]` equals e - 894, plus one when rounding carries out of the fraction.
- R2: For a result that is neither an error nor zero, `out_data[31]` equals the input sign bit `in_data[63]`.
- R3: `out_data[30:0]` equals `in_data[51:21]` rounded to nearest-even. Bit 20 is the guard bit and bits 19..0 are sticky. A tie rounds up only when bit 21 is 1.
- R4: When rounding overflows the 31-bit fraction, the fraction becomes all zero and the exponent byte is one higher. A carry can lift a rebiased exponent of 0 to 1, and it can lift 255 into overflow.
- R5: An input exponent field of 0x7FF (infinity or NaN) gives `out_err` = 1 and `out_data` = 0.
- R6: An input exponent field of 0 (zero or denormal) gives `out_data` = 0 and `out_err` = 0 for either sign.
- R7: A rebiased exponent below 1, counted after any rounding carry, flushes to `out_data` = 0 with `out_err` = 0.
- R8: A rebiased exponent above 255, counted after any rounding carry, gives `out_err` = 1 and `out_data` = 0.
- R9: `in_ready` is 0 during reset and 1 on every cycle after it. `out_valid` is 1 exactly one clock after a cycle with `in_valid` and `in_ready` both high, and is 0 otherwise.
- R10: While `rst_n` is low, `out_valid`, `out_err` and `out_data` are all 0.
- R11: The double for 2π (0x401921FB54442D18) encodes to 0x83490FDAA2. The double with sign 1, exponent field 0x404 and fraction bits 0x255DE728 above a low remainder under one half encodes to 0x86A55DE728.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 64 | IEEE-754 double: sign, 11-bit exponent, 52-bit fraction |
| out_valid | output | 1 | Result word is present |
| out_data | output | 40 | Exponent byte, sign bit, 31-bit fraction |
| out_err | output | 1 | Input has no representation in the target format |

## Verification
The hardest cases to reach are the ones where a rounding carry moves the exponent across a range edge. In those cases the exponent field is 894 or 1149, the kept fraction is all ones and the guard bit is set. Uniform random doubles almost never produce them. The directed stimulus builds these words from their fields, along with exact ties for both fraction parities. The random stream keeps exponents close to the representable window and sometimes forces the dropped bits to an exact half, so ties and carries come up again and again.

// File: rtl/lf_pkg.sv
// Package: format constants shared by the converter and its checker.
// Assumes an IEEE-754 double as the source word and the five-byte legacy
// layout {exponent byte, sign, fraction} as the target word.
package lf_pkg;
    localparam int SRC_EXP_W  = 11;
    localparam int SRC_FRAC_W = 52;
    localparam int SRC_BIAS   = 1023;
    localparam int DST_EXP_W  = 8;
    localparam int DST_FRAC_W = 31;
    localparam int DST_BIAS   = 129;
    localparam int SRC_W      = 1 + SRC_EXP_W + SRC_FRAC_W;
    localparam int DST_W      = DST_EXP_W + 1 + DST_FRAC_W;

    typedef enum logic [1:0] {
        CLS_NORMAL  = 2'd0,
        CLS_ZERO    = 2'd1,
        CLS_SPECIAL = 2'd2
    } lf_class_e;
endpackage

// File: rtl/lf_classify.sv
// Module: lf_classify
// Sorts a source exponent field into zero/denormal, special (inf/NaN) or
// normal. Assumes denormals are handled as zero by the caller.
module lf_classify
    import lf_pkg::*;
#(
    parameter int EXP_W = SRC_EXP_W
) (
    input  logic [EXP_W-1:0] exp_in,
    output lf_class_e        cls
);
    // Purpose: decide the class from the all-zero and all-one exponent codes.
    always_comb begin
        if (exp_in == '0)
            cls = CLS_ZERO;
        else if (&exp_in)
            cls = CLS_SPECIAL;
        else
            cls = CLS_NORMAL;
    end
endmodule

// File: rtl/lf_round.sv
// Module: lf_round
// Shortens a fraction to the target width by round-to-nearest-even and
// reports a carry out of the kept bits. Assumes at least two bits are dropped.
module lf_round #(
    parameter int IN_W  = 52,
    parameter int OUT_W = 31
) (
    input  logic [IN_W-1:0]  frac_in,
    output logic [OUT_W-1:0] frac_out,
    output logic             carry
);
    localparam int DROP = IN_W - OUT_W;

    logic [OUT_W-1:0] kept;
    logic             guard;
    logic             sticky;
    logic             bump;
    logic [OUT_W:0]   sum;

    // Purpose: split the fraction into kept bits, guard bit and sticky bits.
    always_comb begin
        kept   = frac_in[IN_W-1 -: OUT_W];
        guard  = frac_in[DROP-1];
        sticky = |frac_in[DROP-2:0];
    end

    // Purpose: add one when past half, or at half with an odd kept value.
    always_comb begin
        bump     = guard & (sticky | kept[0]);
        sum      = {1'b0, kept} + {{OUT_W{1'b0}}, bump};
        frac_out = sum[OUT_W-1:0];
        carry    = sum[OUT_W];
    end
endmodule

// File: rtl/lf_rebias.sv
// Module: lf_rebias
// Moves a biased exponent to the target bias, folds in a rounding carry and
// flags results above or below the target's usable range 1..2^W-1.
module lf_rebias #(
    parameter int IN_EXP_W  = 11,
    parameter int OUT_EXP_W = 8,
    parameter int IN_BIAS   = 1023,
    parameter int OUT_BIAS  = 129
) (
    input  logic [IN_EXP_W-1:0]  exp_in,
    input  logic                 carry,
    output logic [OUT_EXP_W-1:0] exp_out,
    output logic                 ovf,
    output logic                 unf
);
    localparam int SW = IN_EXP_W + 2;
    localparam logic signed [SW-1:0] OFF_S = SW'(IN_BIAS - OUT_BIAS);
    localparam logic signed [SW-1:0] MAX_S = SW'((2 ** OUT_EXP_W) - 1);
    localparam logic signed [SW-1:0] ONE_S = SW'(1);

    logic signed [SW-1:0] adj;

    // Purpose: signed rebias so underflow shows as a value below one.
    always_comb begin
        adj     = $signed({2'b00, exp_in}) + $signed({{(SW-1){1'b0}}, carry}) - OFF_S;
        ovf     = adj > MAX_S;
        unf     = adj < ONE_S;
        exp_out = adj[OUT_EXP_W-1:0];
    end
endmodule

// File: rtl/f64_to_legacy_float.sv
// Module: f64_to_legacy_float
// Converts a double into the five-byte legacy float {exp8, sign, frac31}.
// The output is registered one cycle after acceptance and there is no
// output back-pressure, so the block is ready on every cycle after reset.
module f64_to_legacy_float
    import lf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SRC_W-1:0] in_data,
    output logic             out_valid,
    output logic [DST_W-1:0] out_data,
    output logic             out_err
);
    logic                  src_sign;
    logic [SRC_EXP_W-1:0]  src_exp;
    logic [SRC_FRAC_W-1:0] src_frac;
    lf_class_e             cls;
    logic [DST_FRAC_W-1:0] rnd_frac;
    logic                  rnd_carry;
    logic [DST_EXP_W-1:0]  new_exp;
    logic                  exp_ovf;
    logic                  exp_unf;
    logic [DST_W-1:0]      nxt_data;
    logic                  nxt_err;
    logic                  rdy_q;

    // Purpose: split the source word into its three fields.
    always_comb begin
        src_sign = in_data[SRC_W-1];
        src_exp  = in_data[SRC_W-2 -: SRC_EXP_W];
        src_frac = in_data[SRC_FRAC_W-1:0];
    end

    lf_classify #(.EXP_W(SRC_EXP_W)) u_cls (
        .exp_in (src_exp),
        .cls    (cls)
    );

    lf_round #(.IN_W(SRC_FRAC_W), .OUT_W(DST_FRAC_W)) u_rnd (
        .frac_in  (src_frac),
        .frac_out (rnd_frac),
        .carry    (rnd_carry)
    );

    lf_rebias #(
        .IN_EXP_W  (SRC_EXP_W),
        .OUT_EXP_W (DST_EXP_W),
        .IN_BIAS   (SRC_BIAS),
        .OUT_BIAS  (DST_BIAS)
    ) u_reb (
        .exp_in  (src_exp),
        .carry   (rnd_carry),
        .exp_out (new_exp),
        .ovf     (exp_ovf),
        .unf     (exp_unf)
    );

    // Purpose: choose the result word and error flag for this input.
    always_comb begin
        nxt_data = '0;
        nxt_err  = 1'b0;
        if (cls == CLS_SPECIAL)
            nxt_err = 1'b1;
        else if (cls == CLS_ZERO || exp_unf)
            nxt_err = 1'b0;
        else if (exp_ovf)
            nxt_err = 1'b1;
        else
            nxt_data = {new_exp, src_sign, rnd_frac};
    end

    // Purpose: ready flag that rises on the first clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdy_q <= 1'b0;
        else
            rdy_q <= 1'b1;
    end

    assign in_ready = rdy_q;

    // Purpose: output register, loaded once per accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid && rdy_q;
            if (in_valid && rdy_q) begin
                out_data <= nxt_data;
                out_err  <= nxt_err;
            end
        end
    end
endmodule

// File: rtl/lf_chk.sv
// Module: lf_chk
// Port-level properties of the converter, bound to every instance of it.
module lf_chk
    import lf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [SRC_W-1:0] in_data,
    input logic             out_valid,
    input logic [DST_W-1:0] out_data,
    input logic             out_err
);
    localparam int LO_EXP = SRC_BIAS - DST_BIAS + 1;
    localparam int HI_EXP = SRC_BIAS - DST_BIAS + (2 ** DST_EXP_W) - 2;

    logic                 acc;
    logic [SRC_EXP_W-1:0] e_in;

    // Purpose: acceptance strobe and exponent field of the input word.
    always_comb begin
        acc  = in_valid && in_ready;
        e_in = in_data[SRC_W-2 -: SRC_EXP_W];
    end

    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);                                                   // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !out_valid);                                                 // R9
    AST_SPECIAL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (&e_in)) |=> (out_err && out_data == '0));                    // R5
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && e_in == '0) |=> (!out_err && out_data == '0));                // R6
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_data == '0);                                          // R8
    AST_SIGN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && int'(e_in) >= LO_EXP && int'(e_in) <= HI_EXP)
        |=> (!out_err && out_data[DST_FRAC_W] == $past(in_data[SRC_W-1])));   // R2
    AST_EXP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data != '0) |-> out_data[DST_W-1 -: DST_EXP_W] != '0); // R7
endmodule

bind f64_to_legacy_float lf_chk i_lf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_err   (out_err)
);

// File: tb/test_f64_to_legacy_float.sv
`timescale 1ns/1ps
module test_f64_to_legacy_float;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [39:0] out_data;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    f64_to_legacy_float i_f64_to_legacy_float (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_err   (out_err)
    );

    // Reference model: bit 40 is the error flag, bits 39..0 the result word.
    function automatic logic [40:0] ref_conv(logic [63:0] d);
        logic [10:0] e;
        logic [63:0] m;
        logic [63:0] q;
        logic [63:0] r;
        int xe;
        e = d[62:52];
        if (e == 11'h7FF) return {1'b1, 40'h0};
        if (e == 11'h000) return 41'h0;
        m = {11'b0, 1'b1, d[51:0]};
        q = m >> 21;
        r = m & 64'h1FFFFF;
        if (r > 64'h100000 || (r == 64'h100000 && q[0])) q = q + 1;
        xe = int'(e) - 1023 + 129;
        if (q[32]) begin
            q  = q >> 1;
            xe = xe + 1;
        end
        if (xe < 1) return 41'h0;
        if (xe > 255) return {1'b1, 40'h0};
        return {1'b0, xe[7:0], d[63], q[30:0]};
    endfunction

    function automatic logic [63:0] mk(logic s, logic [10:0] e, logic [51:0] f);
        return {s, e, f};
    endfunction

    task automatic check(string req, logic [40:0] act, logic [40:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual err=%0b data=%010h expected err=%0b data=%010h",
                     req, act[40], act[39:0], exp[40], exp[39:0]);
        end
    endtask

    // Drive one word at a falling edge, check its result one edge later.
    task automatic send(logic [63:0] d, string req, logic [40:0] exp);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        check({req, " valid"}, {40'h0, out_valid}, 41'h1);
        check(req, {out_err, out_data}, exp);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R10 reset", {out_err, out_data}, 41'h0);
        check("R10 reset valid", {40'h0, out_valid}, 41'h0);
        check("R9 ready in reset", {40'h0, in_ready}, 41'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready after reset", {40'h0, in_ready}, 41'h1);

        send(64'h401921FB54442D18, "R11 two pi", {1'b0, 40'h83490FDAA2});
        send(mk(1'b1, 11'h404, {31'h255DE728, 21'h0AAAA}), "R11 negative constant",
             {1'b0, 40'h86A55DE728});
        send(mk(1'b0, 11'd1023, {31'h0, 1'b1, 20'h0}), "R3 tie even", {1'b0, 40'h8100000000});
        send(mk(1'b0, 11'd1023, {31'h1, 1'b1, 20'h0}), "R3 tie odd", {1'b0, 40'h8100000002});
        send(mk(1'b0, 11'd1023, {31'h0, 1'b1, 20'h1}), "R3 above half", {1'b0, 40'h8100000001});
        send(mk(1'b1, 11'd1023, {31'h7FFFFFFF, 1'b1, 20'h0}), "R4 carry",
             {1'b0, 40'h8280000000});
        send(mk(1'b0, 11'd894, {31'h7FFFFFFF, 1'b1, 20'h0}), "R4 carry lifts to one",
             {1'b0, 40'h0100000000});
        send(mk(1'b0, 11'd895, 52'h0), "R1 lowest exponent", {1'b0, 40'h0100000000});
        send(mk(1'b1, 11'd1149, 52'h0), "R1 highest exponent", {1'b0, 40'hFF80000000});
        send(mk(1'b0, 11'd894, 52'h0), "R7 underflow", 41'h0);
        send(mk(1'b1, 11'd10, 52'hABCDE), "R7 deep underflow", 41'h0);
        send(mk(1'b0, 11'd1150, 52'h0), "R8 overflow", {1'b1, 40'h0});
        send(mk(1'b0, 11'd1149, {31'h7FFFFFFF, 1'b1, 20'h0}), "R8 carry overflow",
             {1'b1, 40'h0});
        send(mk(1'b0, 11'h7FF, 52'h0), "R5 infinity", {1'b1, 40'h0});
        send(mk(1'b1, 11'h7FF, 52'h8000000000001), "R5 NaN", {1'b1, 40'h0});
        send(mk(1'b1, 11'h000, 52'h0), "R6 negative zero", 41'h0);
        send(mk(1'b0, 11'h000, 52'hFFFFFFFFFFFFF), "R6 denormal", 41'h0);
        send(mk(1'b1, 11'd1000, 52'h123456789ABCD), "R2 negative sign",
             ref_conv(mk(1'b1, 11'd1000, 52'h123456789ABCD)));

        in_valid = 1'b0;
        @(negedge clk);
        check("R9 idle", {40'h0, out_valid}, 41'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [10:0] e;
            logic [51:0] f;
            f = {$urandom, $urandom};
            if ($urandom % 8 == 0)
                e = 11'($urandom);
            else
                e = 11'(880 + ($urandom % 285));
            if ($urandom % 4 == 0) f[20:0] = {1'b1, 20'h0};
            if ($urandom % 16 == 0) f[51:21] = 31'h7FFFFFFF;
            d = mk(1'($urandom), e, f);
            if ($urandom % 10 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                check("R9 gap", {40'h0, out_valid}, 41'h0);
            end
            send(d, "R1 R2 R3 random", ref_conv(d));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 final idle", {40'h0, out_valid}, 41'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule